// File: doc/BRIEF.md
# Lane Character Synchronization Tracker

This block keeps track of character-boundary lock for one serial lane of a receiver. It sits between the comma detector and the 8b/10b decoder, takes one character-time of flags on each clock, and reports how far the lane has got in acquiring and holding 10-bit framing. After reset the lane is hunting. It leaves that state only when a comma arrives that the current mode allows to realign the lane. It then passes through a one-character realignment state before it counts as locked.

While locked, a bad character moves the lane into a degraded state. Degraded lanes count bad characters. A full run of consecutive good characters returns the lane to locked and clears the count. Reaching the bad-character limit first drops the lane back to hunting. A change of framing boundary, or reception of the word-alignment sequence, sends any lane that is not hunting back through the realignment state. A realign strobe accompanies every character spent in that state.

Comma qualification depends on the mode pins. With the decoder enabled, commas always qualify. With the decoder bypassed, they qualify only when the comma-enable pin is high.

Top module: `lane_char_sync`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `state_o` is 0 (hunting), `in_sync_o` is 0 and `realign_o` is 0.
- R2: The `state_o` encoding is: 0 hunting, 1 realigning, 2 locked, 3 degraded. `in_sync_o` is 1 exactly when `state_o` is 2 or 3.
- R3: In the hunting state, bad characters, framing changes and word-alignment sequences have no effect. Only a qualified comma moves the lane, and it moves to state 1 on the next cycle.
- R4: With `dec_en_i`=1, a comma qualifies whatever the value of `comma_en_i`.
- R5: With `dec_en_i`=0, a comma qualifies only when `comma_en_i`=1.
- R6: A framing change (`frame_shift_i`=1) in state 1, 2 or 3 puts the lane in state 1 on the next cycle.
- R7: A word-alignment sequence (`wsync_seen_i`=1) in state 1, 2 or 3 puts the lane in state 1 on the next cycle.
- R8: State 1 lasts one cycle and is followed by state 2, unless a new framing change or word-alignment sequence arrives during it.
- R9: `realign_o` is 1 in every cycle in which `state_o` is 1, and 0 in every other cycle.
- R10: A bad character (`bad_char_i`=1) in state 2, with no realignment cause present, leads to state 3 on the next cycle.
- R11: In state 3, the lane returns to state 0 on the BAD_LIMIT-th bad character counted since it entered state 3 (default 4, the entering character included), provided no GOOD_RUN consecutive good characters came in between.
- R12: In state 3, GOOD_RUN consecutive good characters (default 4) return the lane to state 2 and clear the count. A bad character restarts the run.
- R13: A framing change or word-alignment sequence takes priority over a bad character in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock, one character per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| comma_det_i | input | 1 | Comma seen in this character |
| bad_char_i | input | 1 | This character is invalid |
| frame_shift_i | input | 1 | 10-bit framing boundary changed |
| wsync_seen_i | input | 1 | Word-alignment sequence received |
| dec_en_i | input | 1 | Decoder enabled mode |
| comma_en_i | input | 1 | Comma realignment enable used when the decoder is bypassed |
| state_o | output | 2 | Sync state (0 hunting, 1 realigning, 2 locked, 3 degraded) |
| in_sync_o | output | 1 | Lane locked or degraded |
| realign_o | output | 1 | Realignment strobe |

## Verification
Every result is registered once. The flags presented for a character show up in `state_o`, `in_sync_o` and `realign_o` exactly one clock later, and no output lags further behind. The bench applies each character's flags on a falling edge and compares all three outputs at the next falling edge. The edge in between is the one that takes the flags in, so every comparison lands on the cycle in which the result is due. A long mode-cycling sweep checks every cycle against an arithmetic model that counts bad characters and good runs itself, including the limit crossings and the cases where causes coincide.

// File: rtl/csync_pkg.sv
package csync_pkg;

  typedef enum logic [1:0] {
    CS_HUNT     = 2'd0,
    CS_ALIGN    = 2'd1,
    CS_LOCKED   = 2'd2,
    CS_DEGRADED = 2'd3
  } csync_state_e;

  // Comma may realign the lane when decoding is on, or when bypass mode permits it
  function automatic logic comma_counts(input logic dec_en, input logic comma_en,
                                        input logic comma);
    return comma & (dec_en | comma_en);
  endfunction

  // Lane is considered framed once past realignment
  function automatic logic is_framed(input csync_state_e s);
    return (s == CS_LOCKED) || (s == CS_DEGRADED);
  endfunction

endpackage

// File: rtl/csync_qualify.sv
module csync_qualify (
  input  logic comma_det,
  input  logic frame_shift,
  input  logic wsync_seen,
  input  logic dec_en,
  input  logic comma_en,
  output logic qual_comma,
  output logic resync_cause
);
  import csync_pkg::*;

  always_comb begin
    qual_comma   = comma_counts(dec_en, comma_en, comma_det);
    resync_cause = frame_shift | wsync_seen;
  end

endmodule

// File: rtl/csync_err_track.sv
module csync_err_track #(
  parameter int BAD_LIMIT = 4,
  parameter int GOOD_RUN  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  csync_pkg::csync_state_e state,
  input  logic                    bad_char,
  input  logic                    resync_cause,
  output logic                    fail_hit,
  output logic                    recover_hit
);
  import csync_pkg::*;

  localparam int BW = $clog2(BAD_LIMIT + 1);
  localparam int GW = $clog2(GOOD_RUN + 1);

  logic [BW-1:0] bad_cnt;
  logic [GW-1:0] good_cnt;
  logic [BW-1:0] bad_nxt;
  logic [GW-1:0] good_nxt;

  always_comb begin
    bad_nxt     = bad_cnt + BW'(1);
    good_nxt    = good_cnt + GW'(1);
    fail_hit    = (state == CS_DEGRADED) && bad_char && (bad_nxt >= BW'(BAD_LIMIT));
    recover_hit = (state == CS_DEGRADED) && !bad_char && (good_nxt >= GW'(GOOD_RUN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_cnt  <= '0;
      good_cnt <= '0;
    end else if (resync_cause || !is_framed(state)) begin
      bad_cnt  <= '0;
      good_cnt <= '0;
    end else if (state == CS_LOCKED) begin
      if (bad_char) begin
        bad_cnt  <= BW'(1);
        good_cnt <= '0;
      end
    end else if (bad_char) begin
      bad_cnt  <= fail_hit ? '0 : bad_nxt;
      good_cnt <= '0;
    end else if (recover_hit) begin
      bad_cnt  <= '0;
      good_cnt <= '0;
    end else begin
      good_cnt <= good_nxt;
    end
  end

endmodule

// File: rtl/csync_fsm.sv
module csync_fsm (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    qual_comma,
  input  logic                    resync_cause,
  input  logic                    bad_char,
  input  logic                    fail_hit,
  input  logic                    recover_hit,
  output csync_pkg::csync_state_e state,
  output logic                    realign
);
  import csync_pkg::*;

  csync_state_e nxt;
  logic         enter_align;

  always_comb begin
    nxt = state;
    if (state == CS_HUNT) begin
      if (qual_comma) nxt = CS_ALIGN;
    end else if (resync_cause) begin
      nxt = CS_ALIGN;
    end else begin
      case (state)
        CS_ALIGN:    nxt = CS_LOCKED;
        CS_LOCKED:   if (bad_char) nxt = CS_DEGRADED;
        CS_DEGRADED: begin
          if (fail_hit)         nxt = CS_HUNT;
          else if (recover_hit) nxt = CS_LOCKED;
        end
        default:     nxt = CS_HUNT;
      endcase
    end
    enter_align = (state == CS_HUNT) ? qual_comma : resync_cause;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= CS_HUNT;
      realign <= 1'b0;
    end else begin
      state   <= nxt;
      realign <= enter_align;
    end
  end

endmodule

// File: rtl/lane_char_sync.sv
module lane_char_sync #(
  parameter int BAD_LIMIT = 4,
  parameter int GOOD_RUN  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       comma_det_i,
  input  logic       bad_char_i,
  input  logic       frame_shift_i,
  input  logic       wsync_seen_i,
  input  logic       dec_en_i,
  input  logic       comma_en_i,
  output logic [1:0] state_o,
  output logic       in_sync_o,
  output logic       realign_o
);
  import csync_pkg::*;

  logic         qual_comma;
  logic         resync_cause;
  logic         fail_hit;
  logic         recover_hit;
  csync_state_e cur_state;

  csync_qualify u_qual (
    .comma_det   (comma_det_i),
    .frame_shift (frame_shift_i),
    .wsync_seen  (wsync_seen_i),
    .dec_en      (dec_en_i),
    .comma_en    (comma_en_i),
    .qual_comma  (qual_comma),
    .resync_cause(resync_cause)
  );

  csync_err_track #(.BAD_LIMIT(BAD_LIMIT), .GOOD_RUN(GOOD_RUN)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (cur_state),
    .bad_char    (bad_char_i),
    .resync_cause(resync_cause),
    .fail_hit    (fail_hit),
    .recover_hit (recover_hit)
  );

  csync_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .qual_comma  (qual_comma),
    .resync_cause(resync_cause),
    .bad_char    (bad_char_i),
    .fail_hit    (fail_hit),
    .recover_hit (recover_hit),
    .state       (cur_state),
    .realign     (realign_o)
  );

  assign state_o   = cur_state;
  assign in_sync_o = is_framed(cur_state);

endmodule

// File: rtl/csync_checker.sv
module csync_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       comma_det_i,
  input logic       bad_char_i,
  input logic       dec_en_i,
  input logic       comma_en_i,
  input logic [1:0] state_o,
  input logic       realign_o,
  input logic       resync_cause
);

  AST_HUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && !(comma_det_i && (dec_en_i || comma_en_i))) |=> (state_o == 2'd0)); // R3

  AST_BYPASS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && !dec_en_i && !comma_en_i) |=> (state_o == 2'd0)); // R5

  AST_DECODE_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && dec_en_i && comma_det_i) |=> (state_o == 2'd1)); // R4

  AST_RESYNC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd0 && resync_cause) |=> (state_o == 2'd1)); // R6

  AST_ALIGN_ONE_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && !resync_cause) |=> (state_o == 2'd2)); // R8

  AST_STROBE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    realign_o |-> (state_o == 2'd1)); // R9

  AST_LOCK_DEGRADE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && bad_char_i && !resync_cause) |=> (state_o == 2'd3)); // R10

  AST_DEGRADE_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3 && bad_char_i && !resync_cause) |=> (state_o == 2'd3 || state_o == 2'd0)); // R11

endmodule

bind lane_char_sync csync_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .comma_det_i (comma_det_i),
  .bad_char_i  (bad_char_i),
  .dec_en_i    (dec_en_i),
  .comma_en_i  (comma_en_i),
  .state_o     (state_o),
  .realign_o   (realign_o),
  .resync_cause(resync_cause)
);

// File: tb/sim_lane_char_sync.sv
`timescale 1ns/1ps
module sim_lane_char_sync;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NBAD       = 4;
  localparam int NGOOD      = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic comma = 1'b0, bad = 1'b0, fsh = 1'b0, ws = 1'b0, dec = 1'b0, cen = 1'b0;
  logic [1:0] state_o;
  logic in_sync_o, realign_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  // independent model
  int m_st = 0;
  int m_bad = 0;
  int m_good = 0;
  bit m_rl = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_char_sync u0 (
    .clk(clk), .rst_n(rst_n), .comma_det_i(comma), .bad_char_i(bad),
    .frame_shift_i(fsh), .wsync_seen_i(ws), .dec_en_i(dec), .comma_en_i(cen),
    .state_o(state_o), .in_sync_o(in_sync_o), .realign_o(realign_o)
  );

  task automatic chk(input string tag, input int es, input bit ei, input bit er);
    checks++;
    if (state_o !== 2'(es) || in_sync_o !== ei || realign_o !== er) begin
      fails++;
      $display("FAIL %s: state/in_sync/realign = %0d/%0b/%0b expected %0d/%0b/%0b",
               tag, state_o, in_sync_o, realign_o, es, ei, er);
    end
  endtask

  // model advances one character from the flags applied now
  task automatic model_step();
    bit q, t;
    q = comma && (dec || cen);
    t = fsh || ws;
    m_rl = 1'b0;
    if (m_st == 0) begin
      if (q) begin m_st = 1; m_rl = 1'b1; end
    end else if (t) begin
      m_st = 1; m_rl = 1'b1; m_bad = 0; m_good = 0;
    end else if (m_st == 1) begin
      m_st = 2; m_bad = 0; m_good = 0;
    end else if (m_st == 2) begin
      if (bad) begin m_st = 3; m_bad = 1; m_good = 0; end
    end else begin
      if (bad) begin
        m_bad = m_bad + 1; m_good = 0;
        if (m_bad >= NBAD) begin m_st = 0; m_bad = 0; end
      end else begin
        m_good = m_good + 1;
        if (m_good >= NGOOD) begin m_st = 2; m_bad = 0; m_good = 0; end
      end
    end
  endtask

  // apply one character's flags at a falling edge; outputs due one clock later
  task automatic step(input bit c, input bit b, input bit f, input bit w);
    comma = c; bad = b; fsh = f; ws = w;
    model_step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    comma = 0; bad = 0; fsh = 0; ws = 0;
    m_st = 0; m_bad = 0; m_good = 0; m_rl = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      fails++;
      $display("FAIL watchdog: cycles %0d expected below %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    chk("R1 in reset", 0, 0, 0);
    do_reset();
    chk("R1 after reset", 0, 0, 0);

    dec = 0; cen = 0;
    step(1, 0, 0, 0); chk("R5 bypass comma blocked", 0, 0, 0);
    step(0, 1, 1, 1); chk("R3 hunt ignores flags", 0, 0, 0);
    cen = 1;
    step(1, 0, 0, 0); chk("R5 bypass comma enabled / R9", 1, 0, 1);
    step(0, 0, 0, 0); chk("R8 R2 locked", 2, 1, 0);
    step(0, 1, 0, 0); chk("R10 degrade", 3, 1, 0);
    step(1, 0, 0, 0); chk("R12 run 1", 3, 1, 0);
    step(0, 0, 0, 0); chk("R12 run 2", 3, 1, 0);
    step(0, 0, 0, 0); chk("R12 run 3", 3, 1, 0);
    step(0, 1, 0, 0); chk("R11 bad 2", 3, 1, 0);
    step(0, 1, 0, 0); chk("R11 bad 3", 3, 1, 0);
    step(0, 1, 0, 0); chk("R11 bad 4 to hunt", 0, 0, 0);

    dec = 1; cen = 0;
    step(1, 0, 0, 0); chk("R4 decoder comma", 1, 0, 1);
    step(0, 0, 0, 0); chk("R8 locked", 2, 1, 0);
    step(0, 1, 0, 0); chk("R10 degrade", 3, 1, 0);
    for (int i = 0; i < NGOOD - 1; i++) begin
      step(0, 0, 0, 0); chk("R12 partial run", 3, 1, 0);
    end
    step(0, 0, 0, 0); chk("R12 recover", 2, 1, 0);
    step(0, 1, 0, 1); chk("R13 R7 priority", 1, 0, 1);
    step(0, 0, 1, 0); chk("R6 shift in align", 1, 0, 1);
    step(0, 0, 0, 0); chk("R8 locked", 2, 1, 0);
    step(0, 0, 1, 0); chk("R6 shift in locked", 1, 0, 1);
    step(0, 0, 0, 0); chk("R9 strobe drops", 2, 1, 0);
    step(0, 1, 0, 0); chk("R10 degrade", 3, 1, 0);
    step(0, 0, 0, 1); chk("R7 wsync in degraded", 1, 0, 1);
    step(0, 0, 0, 0); chk("R8 locked", 2, 1, 0);
    step(0, 1, 0, 0); chk("R10 degrade", 3, 1, 0);
    for (int i = 0; i < NGOOD - 1; i++) step(0, 0, 0, 0);
    step(0, 1, 0, 0); chk("R12 run restarted by bad", 3, 1, 0);
    for (int i = 0; i < NGOOD - 1; i++) step(0, 0, 0, 0);
    chk("R12 short run stays", 3, 1, 0);
    step(0, 1, 0, 0); chk("R11 bad 3", 3, 1, 0);
    step(0, 1, 0, 0); chk("R11 limit", 0, 0, 0);

    // sweep against model, cycling modes
    do_reset();
    chk("R1 sweep reset", 0, 0, 0);
    lfsr = 16'hACE1;
    for (int m = 0; m < 4; m++) begin
      dec = m[1]; cen = m[0];
      for (int n = 0; n < 1500; n++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[1:0] == 2'b11, lfsr[4:2] == 3'b101 || lfsr[4:2] == 3'b011,
             lfsr[9:5] == 5'b10110, lfsr[14:10] == 5'b01101);
        chk("R2 model sweep", m_st, (m_st >= 2), m_rl);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule